// File: doc/BRIEF.md
# Serial command periphery controller

This block sits in the periphery of a pixel-array chip and turns a bit stream from one external pin into control actions for the column ends. Each bit on `ser_in` is taken when `ser_valid` is high. Fourteen such bits, most significant first, form one command word. When the last bit arrives the word is decoded. It can start a column readout, a per-pixel configuration write, a write to one of the global configuration registers, or an array reset. While a command is running, `busy` is high and the stream is not parsed for new commands.

Readout and pixel configuration act on a column group. The group is one, two or four adjacent columns starting at a given column, or every column. During a pixel configuration the serial bits that follow the command are passed out one at a time. Each bit goes out on every selected column in parallel, so the array only needs a slow clock. A global register write takes the next eight bits into one of eight 8-bit registers. The shutter and analog power-off lines follow their pins. The test-pulse line follows its pin only once the array has been configured.

Top module: `cmd_periph_ctrl`

## Requirements
- R1: After reset, `busy`, `col_sel`, `col_readout`, `col_load`, `col_data`, `array_rst` and `test_pulse` are 0, and every global register reads 0.
- R2: A command is 14 bits sent MSB first, one bit per cycle in which `ser_valid` is high. The fields are bits [13:11] opcode, [10:9] group size code, [8:3] start column and [2:0] register address. The command executes after the 14th bit, and `busy` is high from the clock edge that takes that bit.
- R3: The column group mask is 1, 2 or 4 columns starting at the start column for size codes 00, 01 and 10. The group is cut off at the last column. Code 11 selects all columns, whatever the start column is.
- R4: Opcode 001 (readout) holds `col_readout` high and `col_sel` equal to the group mask for RD_LEN (8) cycles. After that `busy`, `col_readout` and `col_sel` return to 0.
- R5: Opcode 010 (pixel configuration) holds `col_sel` at the group mask. It then takes the next CFG_LEN (4) valid bits. For each one, in the same cycle, `col_load` is 1 and `col_data` is the mask ANDed with that bit. After the last bit the block is idle.
- R6: Opcode 011 (global write) shifts the next 8 valid bits, MSB first, into register `addr`. The new value shows on `greg_out[addr*8 +: 8]` after the edge that takes the 8th bit. The other registers keep their values.
- R7: Opcode 100 (array reset) drives `array_rst` and `busy` high for exactly one cycle.
- R8: Opcodes 000, 101, 110 and 111 do nothing and do not raise `busy`. Bits given while a readout is running are ignored, and the next command is decoded normally.
- R9: `shutter` and `analog_off` follow `shutter_pin` and `poweroff_pin`. `test_pulse` equals `tpulse_pin` only while the configured flag is set. That flag is set when a pixel configuration completes and cleared by an array reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial command and payload bit |
| ser_valid | input | 1 | Qualifies `ser_in` in this cycle |
| shutter_pin | input | 1 | External shutter request |
| poweroff_pin | input | 1 | External analog power-off request |
| tpulse_pin | input | 1 | External test-pulse request |
| busy | output | 1 | A command is executing |
| col_sel | output | 64 | Selected columns during readout or configuration |
| col_readout | output | 1 | Readout active |
| col_load | output | 1 | A configuration bit is on `col_data` |
| col_data | output | 64 | Configuration bit per column |
| array_rst | output | 1 | One-cycle array reset |
| shutter | output | 1 | Shutter to the array |
| analog_off | output | 1 | Analog power-off to the array |
| test_pulse | output | 1 | Gated test pulse |
| greg_out | output | 64 | Eight 8-bit global registers, register k at bits [8k+7:8k] |

## Verification
The bench aims at the edges of the column mask: a group that starts near the last column, which must be cut off rather than wrap to column 0, and the all-columns code with a nonzero start, which a wrong decoder would turn into a narrow group. It feeds bits during a readout and then sends a fresh command. A receiver that kept counting while busy would misalign that command and write the wrong register. It checks that unused opcodes leave `busy` low, that `test_pulse` stays low before configuration and after an array reset, and that a global write leaves the other seven registers untouched. Random commands then cover the group sizes, start columns, payloads and register addresses.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
  localparam logic [2:0] OP_READ = 3'd1;
  localparam logic [2:0] OP_PCFG = 3'd2;
  localparam logic [2:0] OP_GWR  = 3'd3;
  localparam logic [2:0] OP_ARST = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_PCFG, S_GWR, S_ARST
  } seq_st_t;

  // number of columns named by a group size code
  function automatic int grp_count(input logic [1:0] code, input int ncol);
    case (code)
      2'b00:   return 1;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return ncol;
    endcase
  endfunction
endpackage

// File: rtl/cmdp_rx.sv
module cmdp_rx #(
  parameter int CMD_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             ser_valid,
  input  logic             accept,
  output logic             cmd_done,
  output logic [CMD_W-1:0] cmd_word
);
  localparam int CNTW = $clog2(CMD_W);

  logic [CMD_W-2:0] sr;
  logic [CNTW-1:0]  cnt;
  logic             take;

  assign take     = accept && ser_valid;
  assign cmd_done = take && (cnt == CNTW'(CMD_W-1));
  assign cmd_word = {sr, ser_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (take) begin
      sr  <= {sr[CMD_W-3:0], ser_in};
      cnt <= cmd_done ? '0 : cnt + 1'b1;
    end
  end

  // R2: the bit counter never runs past one word
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(CMD_W-1));
endmodule

// File: rtl/cmdp_seq.sv
module cmdp_seq
  import cmdp_pkg::*;
#(
  parameter int NCOL    = 64,
  parameter int AW      = 3,
  parameter int RD_LEN  = 8,
  parameter int CFG_LEN = 4,
  parameter int GREG_W  = 8,
  localparam int COLW   = $clog2(NCOL),
  localparam int CMD_W  = 5 + COLW + AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              ser_valid,
  input  logic              cmd_done,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic              busy,
  output logic [NCOL-1:0]   col_sel,
  output logic              col_readout,
  output logic              col_load,
  output logic [NCOL-1:0]   col_data,
  output logic              array_rst,
  output logic              cfg_done,
  output logic              greg_we,
  output logic [AW-1:0]     greg_addr,
  output logic [GREG_W-1:0] greg_wdata
);
  localparam int MAXL = (RD_LEN > CFG_LEN) ? ((RD_LEN > GREG_W) ? RD_LEN : GREG_W)
                                           : ((CFG_LEN > GREG_W) ? CFG_LEN : GREG_W);
  localparam int CW = (MAXL > 1) ? $clog2(MAXL) : 1;

  function automatic logic [NCOL-1:0] col_mask(input logic [1:0] code,
                                               input logic [COLW-1:0] start);
    logic [NCOL-1:0] m;
    int n;
    n = grp_count(code, NCOL);
    for (int c = 0; c < NCOL; c++)
      m[c] = (code == 2'b11) || ((c >= int'(start)) && (c < int'(start) + n));
    return m;
  endfunction

  logic [2:0]      f_op;
  logic [1:0]      f_size;
  logic [COLW-1:0] f_start;
  logic [AW-1:0]   f_addr;

  assign f_op    = cmd_word[CMD_W-1 -: 3];
  assign f_size  = cmd_word[CMD_W-4 -: 2];
  assign f_start = cmd_word[AW +: COLW];
  assign f_addr  = cmd_word[AW-1:0];

  seq_st_t           st;
  logic [NCOL-1:0]   mask_q;
  logic [AW-1:0]     addr_q;
  logic [CW-1:0]     cnt;
  logic [GREG_W-2:0] sh;
  logic              rd_last, bit_in_cfg, bit_in_gwr;

  assign rd_last    = (st == S_READ) && (cnt == CW'(RD_LEN-1));
  assign bit_in_cfg = (st == S_PCFG) && ser_valid;
  assign bit_in_gwr = (st == S_GWR) && ser_valid;

  assign busy        = (st != S_IDLE);
  assign col_readout = (st == S_READ);
  assign col_sel     = (st == S_READ || st == S_PCFG) ? mask_q : '0;
  assign col_load    = bit_in_cfg;
  assign col_data    = bit_in_cfg ? (mask_q & {NCOL{ser_in}}) : '0;
  assign cfg_done    = bit_in_cfg && (cnt == CW'(CFG_LEN-1));
  assign array_rst   = (st == S_ARST);
  assign greg_we     = bit_in_gwr && (cnt == CW'(GREG_W-1));
  assign greg_addr   = addr_q;
  assign greg_wdata  = {sh, ser_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mask_q <= '0;
      addr_q <= '0;
      cnt    <= '0;
      sh     <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_done) begin
          mask_q <= col_mask(f_size, f_start);
          addr_q <= f_addr;
          cnt    <= '0;
          case (f_op)
            OP_READ: st <= S_READ;
            OP_PCFG: st <= S_PCFG;
            OP_GWR:  st <= S_GWR;
            OP_ARST: st <= S_ARST;
            default: st <= S_IDLE;
          endcase
        end
        S_READ: begin
          if (rd_last) st <= S_IDLE;
          else         cnt <= cnt + 1'b1;
        end
        S_PCFG: if (ser_valid) begin
          if (cfg_done) st <= S_IDLE;
          else          cnt <= cnt + 1'b1;
        end
        S_GWR: if (ser_valid) begin
          sh <= greg_wdata[GREG_W-2:0];
          if (greg_we) st <= S_IDLE;
          else         cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7: array reset lasts one cycle and frees the block
  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    array_rst |=> (!array_rst && !busy));
  // R8: nothing reaches the columns while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (col_sel == '0 && !col_load && !col_readout));
  // R3: a readout group is nonempty and 1..4 columns or all of them
  p_grp_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    col_readout |-> (col_sel != '0 && ($countones(col_sel) <= 4 || &col_sel)));
  // R2: a command is only completed while no other runs
  p_cmd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !busy);
  // R4: the group stays fixed through a readout
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_readout && $past(col_readout)) |-> $stable(col_sel));
endmodule

// File: rtl/cmdp_greg.sv
module cmdp_greg #(
  parameter int N  = 8,
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [W-1:0]   wdata,
  output logic [N*W-1:0] regs_flat
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     r <= '0;
      else if (we && addr == AW'(g))  r <= wdata;
    end
    assign regs_flat[g*W +: W] = r;
  end

  // R6: registers change only on a write strobe
  p_greg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_flat));
endmodule

// File: rtl/cmd_periph_ctrl.sv
module cmd_periph_ctrl #(
  parameter int NCOL    = 64,
  parameter int NGREG   = 8,
  parameter int GREG_W  = 8,
  parameter int RD_LEN  = 8,
  parameter int CFG_LEN = 4,
  localparam int AW     = $clog2(NGREG),
  localparam int COLW   = $clog2(NCOL),
  localparam int CMD_W  = 5 + COLW + AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_in,
  input  logic                    ser_valid,
  input  logic                    shutter_pin,
  input  logic                    poweroff_pin,
  input  logic                    tpulse_pin,
  output logic                    busy,
  output logic [NCOL-1:0]         col_sel,
  output logic                    col_readout,
  output logic                    col_load,
  output logic [NCOL-1:0]         col_data,
  output logic                    array_rst,
  output logic                    shutter,
  output logic                    analog_off,
  output logic                    test_pulse,
  output logic [NGREG*GREG_W-1:0] greg_out
);
  logic             cmd_done, cfg_done, greg_we, configured;
  logic [CMD_W-1:0] cmd_word;
  logic [AW-1:0]    greg_addr;
  logic [GREG_W-1:0] greg_wdata;

  cmdp_rx #(.CMD_W(CMD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_valid(ser_valid),
    .accept(!busy), .cmd_done(cmd_done), .cmd_word(cmd_word)
  );

  cmdp_seq #(.NCOL(NCOL), .AW(AW), .RD_LEN(RD_LEN), .CFG_LEN(CFG_LEN),
             .GREG_W(GREG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_valid(ser_valid),
    .cmd_done(cmd_done), .cmd_word(cmd_word), .busy(busy),
    .col_sel(col_sel), .col_readout(col_readout), .col_load(col_load),
    .col_data(col_data), .array_rst(array_rst), .cfg_done(cfg_done),
    .greg_we(greg_we), .greg_addr(greg_addr), .greg_wdata(greg_wdata)
  );

  cmdp_greg #(.N(NGREG), .W(GREG_W), .AW(AW)) u_greg (
    .clk(clk), .rst_n(rst_n), .we(greg_we), .addr(greg_addr),
    .wdata(greg_wdata), .regs_flat(greg_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         configured <= 1'b0;
    else if (array_rst) configured <= 1'b0;
    else if (cfg_done)  configured <= 1'b1;
  end

  assign shutter    = shutter_pin;
  assign analog_off = poweroff_pin;
  assign test_pulse = tpulse_pin && configured;

  // R9: no test pulse in the cycle after an array reset
  p_tp_after_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    array_rst |=> !test_pulse);
  // R9: test pulse becomes possible only after a completed configuration
  p_tp_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(test_pulse) && $past(tpulse_pin)) |-> $past(cfg_done));
endmodule

// File: tb/cmd_periph_ctrl_test.sv
module cmd_periph_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic ser_in = 0, ser_valid = 0, shutter_pin = 0, poweroff_pin = 0, tpulse_pin = 0;
  logic busy, col_readout, col_load, array_rst, shutter, analog_off, test_pulse;
  logic [63:0] col_sel, col_data, greg_out;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] gm [8];
  bit finished = 0;

  cmd_periph_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_valid(ser_valid),
    .shutter_pin(shutter_pin), .poweroff_pin(poweroff_pin), .tpulse_pin(tpulse_pin),
    .busy(busy), .col_sel(col_sel), .col_readout(col_readout), .col_load(col_load),
    .col_data(col_data), .array_rst(array_rst), .shutter(shutter),
    .analog_off(analog_off), .test_pulse(test_pulse), .greg_out(greg_out)
  );

  always #5 clk = ~clk;

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_mask(logic [1:0] sz, logic [5:0] st);
    logic [63:0] m = '0;
    int w;
    if (sz == 2'b11) return '1;
    w = 1 << sz;
    for (int k = 0; k < w; k++)
      if (int'(st) + k < 64) m[int'(st) + k] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] greg_model();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = gm[k];
    return v;
  endfunction

  task automatic send_cmd(logic [2:0] op, logic [1:0] sz, logic [5:0] st, logic [2:0] ad);
    logic [13:0] w = {op, sz, st, ad};
    for (int i = 13; i >= 0; i--) begin
      ser_in = w[i]; ser_valid = 1; tick();
    end
    ser_valid = 0;
  endtask

  task automatic do_gwr(logic [2:0] ad, logic [7:0] d);
    send_cmd(3'd3, 2'b00, 6'd0, ad);
    chk("R2 busy after gwr cmd", {63'd0, busy}, 64'd1);
    for (int i = 7; i >= 0; i--) begin
      ser_in = d[i]; ser_valid = 1; tick();
    end
    ser_valid = 0;
    gm[ad] = d;
    chk("R6 greg value", greg_out, greg_model());
    chk("R6 busy released", {63'd0, busy}, 64'd0);
  endtask

  task automatic do_read(logic [1:0] sz, logic [5:0] st, bit noise);
    logic [63:0] m = exp_mask(sz, st);
    send_cmd(3'd1, sz, st, 3'd0);
    for (int i = 0; i < 8; i++) begin
      if (noise) begin ser_in = 1'($urandom); ser_valid = 1'($urandom); end
      chk("R4 readout active", {62'd0, busy, col_readout}, 64'd3);
      chk("R3 readout mask", col_sel, m);
      tick();
    end
    ser_valid = 0;
    chk("R4 readout ended", {61'd0, busy, col_readout, |col_sel}, 64'd0);
  endtask

  task automatic do_pcfg(logic [1:0] sz, logic [5:0] st);
    logic [63:0] m = exp_mask(sz, st);
    send_cmd(3'd2, sz, st, 3'd0);
    chk("R5 cfg mask", col_sel, m);
    for (int i = 0; i < 4; i++) begin
      ser_in = 1'($urandom); ser_valid = 1; #1;
      chk("R5 col_load", {63'd0, col_load}, 64'd1);
      chk("R5 col_data", col_data, ser_in ? m : 64'd0);
      tick();
    end
    ser_valid = 0;
    chk("R5 cfg ended", {62'd0, busy, col_load}, 64'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 8; k++) gm[k] = 8'h00;
    tpulse_pin = 1;
    repeat (3) tick();
    chk("R1 reset outputs", {57'd0, busy, col_readout, col_load, array_rst, test_pulse,
        |col_sel, |col_data}, 64'd0);
    chk("R1 reset greg", greg_out, 64'd0);
    rst_n = 1; tick();

    // R9 pin following and gating before configuration
    shutter_pin = 1; poweroff_pin = 0; #1;
    chk("R9 shutter/poweroff", {62'd0, shutter, analog_off}, 64'd2);
    shutter_pin = 0; poweroff_pin = 1; #1;
    chk("R9 shutter/poweroff", {62'd0, shutter, analog_off}, 64'd1);
    chk("R9 test_pulse unconfigured", {63'd0, test_pulse}, 64'd0);

    // R8 unused opcodes
    send_cmd(3'd6, 2'b11, 6'd9, 3'd1);
    chk("R8 nop opcode busy", {63'd0, busy}, 64'd0);
    send_cmd(3'd0, 2'b00, 6'd0, 3'd0);
    chk("R8 nop opcode busy", {63'd0, busy}, 64'd0);

    do_gwr(3'd5, 8'hA5);
    do_gwr(3'd0, 8'h81);

    // R3 all-columns code with nonzero start; R8 noise while busy
    do_read(2'b11, 6'd10, 1'b1);
    do_gwr(3'd2, 8'h3C);
    // R3 clipping at the last column
    do_read(2'b10, 6'd62, 1'b0);
    do_read(2'b01, 6'd63, 1'b0);

    do_pcfg(2'b00, 6'd5);
    tpulse_pin = 1; #1;
    chk("R9 test_pulse configured", {63'd0, test_pulse}, 64'd1);
    tpulse_pin = 0; #1;
    chk("R9 test_pulse pin low", {63'd0, test_pulse}, 64'd0);
    tpulse_pin = 1;

    // R7 array reset
    send_cmd(3'd4, 2'b00, 6'd0, 3'd0);
    chk("R7 array_rst pulse", {62'd0, array_rst, busy}, 64'd3);
    tick();
    chk("R7 array_rst ended", {62'd0, array_rst, busy}, 64'd0);
    chk("R9 test_pulse after reset", {63'd0, test_pulse}, 64'd0);

    for (int it = 0; it < 40; it++) begin
      int sel = $urandom_range(2, 0);
      logic [1:0] sz = 2'($urandom);
      logic [5:0] st = 6'($urandom);
      case (sel)
        0: do_read(sz, st, 1'($urandom));
        1: do_pcfg(sz, st);
        default: do_gwr(3'($urandom), 8'($urandom));
      endcase
    end
    chk("R6 final greg", greg_out, greg_model());

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule